// File: doc/BRIEF.md
# Shared-Line Serial Programmer for Synthesizer and DAC

This block loads configuration words into two external radio peripherals, a frequency synthesizer and a serial DAC. Both sit on one serial clock line and one serial data line. Each peripheral has its own active-low enable strobe, and the strobe alone decides which of the two takes the word. The serial clock runs at half the block clock, which is the radio reference clock. Each bit is placed on the data line while the serial clock is low, so it is already stable when the clock rises. The selected strobe stays low for the whole word. The peripheral commits the word when that strobe rises.

A request arrives on a valid/ready handshake. The request carries a target select, a DAC length select and a right-aligned word. A request is taken only in a cycle where both `req_valid` and `req_ready` are high. The requester must hold its fields steady until that cycle, and it may drop `req_valid` at any point before it. `req_ready` is low for the whole of a transfer. It is also low for synthesizer requests while the radio is not idle, so a synthesizer word waits until the radio goes idle. DAC words are taken whatever the radio state. This lets the transmit-power value be loaded as a transmission starts and the threshold value as a reception starts. `busy` covers each transfer, and a one-cycle `done` pulse closes it.

Top module: `serprog_top`

## Requirements
- R1: During and straight after reset, both enables are high, `ser_clk` and `ser_dat` are low, `busy` and `done` are low.
- R2: Each bit occupies two block-clock cycles, the first with `ser_clk` low and the second with `ser_clk` high. `ser_clk` is low whenever no bit is being shifted.
- R3: Bits leave MSB first, starting at bit L-1 of `req_word`, where L is the word length. `ser_dat` changes only at the start of a low clock phase and is low outside the shift.
- R4: `req_dac`=0 selects the synthesizer enable `syn_en_n`, and `req_dac`=1 selects the DAC enable `dac_en_n`. Only the selected enable goes low, the two are never low together, and both are high when no transfer is active.
- R5: The selected enable goes low in the first cycle after acceptance. It stays low through all bit cycles and through one further cycle with the clock low, then it rises.
- R6: `done` is high for exactly one cycle, the cycle in which the enable has just risen. `busy` is high from the first cycle after acceptance through the `done` cycle.
- R7: Synthesizer words are SYN_BITS long (24 by default). DAC words are 10 bits when `req_long`=0 and 12 bits when `req_long`=1. Bits of `req_word` above the length are not sent.
- R8: `req_ready` is high only when no transfer is active and either `req_dac`=1 or `radio_idle`=1. A request offered while `req_ready` is low has no effect on any output.
- R9: A DAC request is accepted while `radio_idle`=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Radio reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| radio_idle | input | 1 | High while the radio is neither sending nor receiving |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request can be taken this cycle |
| req_dac | input | 1 | 0 = synthesizer target, 1 = DAC target |
| req_long | input | 1 | DAC length: 0 = 10 bits, 1 = 12 bits |
| req_word | input | WORD_W | Right-aligned word to send |
| ser_clk | output | 1 | Shared serial clock |
| ser_dat | output | 1 | Shared serial data |
| syn_en_n | output | 1 | Synthesizer enable, active low |
| dac_en_n | output | 1 | DAC enable, active low |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle pulse after the enable rises |

## Verification
The assertions assume that every request input and `radio_idle` is known after reset and changes only between clock edges. Without that, the acceptance check, which ties a synthesizer handshake to an idle radio, would see values from the wrong side of an edge. The stimulus drives every input one time step after the falling clock edge and samples outputs on the falling edge. It switches `radio_idle` both while requests are pending and in the middle of transfers, and it holds `req_valid` high across whole transfers so that offers made while busy are exercised.

// File: rtl/serprog_pkg.sv
package serprog_pkg;
  typedef enum logic [1:0] {
    SP_IDLE  = 2'd0,
    SP_SHIFT = 2'd1,
    SP_TAIL  = 2'd2,
    SP_DONE  = 2'd3
  } sp_state_e;
endpackage

// File: rtl/serprog_shifter.sv
module serprog_shifter #(
  parameter int WORD_W = 24,
  parameter int LEN_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [WORD_W-1:0] word,
  input  logic [LEN_W-1:0]  len,
  input  logic              advance,
  output logic              msb,
  output logic              last
);
  logic [WORD_W-1:0] sr;
  logic [LEN_W-1:0]  left;

  // the word is left-aligned at load, so the bits above the length fall off
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sr   <= '0;
      left <= '0;
    end else if (load) begin
      sr   <= word << (LEN_W'(WORD_W) - len);
      left <= len;
    end else if (advance) begin
      sr   <= {sr[WORD_W-2:0], 1'b0};
      left <= left - LEN_W'(1);
    end
  end

  assign msb  = sr[WORD_W-1];
  assign last = (left == LEN_W'(1));
endmodule

// File: rtl/serprog_seq.sv
module serprog_seq
  import serprog_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic req_valid,
  input  logic req_dac,
  input  logic radio_idle,
  input  logic last,
  output logic req_ready,
  output logic load,
  output logic advance,
  output logic shifting,
  output logic ser_clk,
  output logic syn_en_n,
  output logic dac_en_n,
  output logic busy,
  output logic done
);
  sp_state_e state;
  logic      phase;
  logic      tgt;
  logic      active;

  assign req_ready = (state == SP_IDLE) && (req_dac || radio_idle);
  assign load      = req_valid && req_ready;
  assign shifting  = (state == SP_SHIFT);
  assign advance   = shifting && phase && !last;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= SP_IDLE;
      phase <= 1'b0;
      tgt   <= 1'b0;
    end else begin
      case (state)
        SP_IDLE: if (load) begin
          state <= SP_SHIFT;
          phase <= 1'b0;
          tgt   <= req_dac;
        end
        SP_SHIFT: begin
          phase <= !phase;
          if (phase && last) state <= SP_TAIL;
        end
        SP_TAIL: state <= SP_DONE;
        default: state <= SP_IDLE;
      endcase
    end
  end

  assign active   = shifting || (state == SP_TAIL);
  assign ser_clk  = shifting && phase;
  assign syn_en_n = !(active && !tgt);
  assign dac_en_n = !(active && tgt);
  assign busy     = (state != SP_IDLE);
  assign done     = (state == SP_DONE);
endmodule

// File: rtl/serprog_top.sv
module serprog_top #(
  parameter int WORD_W    = 24,
  parameter int SYN_BITS  = 24,
  parameter int DAC_SHORT = 10,
  parameter int DAC_LONG  = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              radio_idle,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_dac,
  input  logic              req_long,
  input  logic [WORD_W-1:0] req_word,
  output logic              ser_clk,
  output logic              ser_dat,
  output logic              syn_en_n,
  output logic              dac_en_n,
  output logic              busy,
  output logic              done
);
  localparam int LEN_W = $clog2(WORD_W + 1);

  logic             load, advance, shifting, msb, last;
  logic [LEN_W-1:0] len;

  assign len = req_dac ? (req_long ? LEN_W'(DAC_LONG) : LEN_W'(DAC_SHORT))
                       : LEN_W'(SYN_BITS);

  serprog_seq u_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_dac(req_dac),
    .radio_idle(radio_idle), .last(last), .req_ready(req_ready),
    .load(load), .advance(advance), .shifting(shifting), .ser_clk(ser_clk),
    .syn_en_n(syn_en_n), .dac_en_n(dac_en_n), .busy(busy), .done(done)
  );

  serprog_shifter #(.WORD_W(WORD_W), .LEN_W(LEN_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .load(load), .word(req_word), .len(len),
    .advance(advance), .msb(msb), .last(last)
  );

  assign ser_dat = shifting && msb;
endmodule

// File: rtl/serprog_chk.sv
module serprog_chk (
  input logic clk,
  input logic rst_n,
  input logic req_valid,
  input logic req_ready,
  input logic req_dac,
  input logic radio_idle,
  input logic ser_clk,
  input logic ser_dat,
  input logic syn_en_n,
  input logic dac_en_n,
  input logic busy,
  input logic done
);
  AST_EN_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    syn_en_n || dac_en_n); // R4
  AST_CLK_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    ser_clk |-> (!syn_en_n || !dac_en_n)); // R2
  AST_CLK_HIGH_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    ser_clk |=> !ser_clk); // R2
  AST_DAT_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ser_clk) |-> $stable(ser_dat)); // R3
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R6
  AST_DONE_AFTER_EN: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (syn_en_n && dac_en_n && $past(!syn_en_n || !dac_en_n))); // R5
  AST_SYN_NEEDS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !req_dac) |-> radio_idle); // R8
  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !req_ready); // R8
endmodule

bind serprog_top serprog_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_dac(req_dac), .radio_idle(radio_idle), .ser_clk(ser_clk),
  .ser_dat(ser_dat), .syn_en_n(syn_en_n), .dac_en_n(dac_en_n),
  .busy(busy), .done(done)
);

// File: tb/sim_serprog_top.sv
module sim_serprog_top;
  localparam int CLK_PERIOD = 10;
  localparam int WORD_W     = 24;
  localparam int SYN_BITS   = 24;
  localparam int WDOG       = 20000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic radio_idle = 1'b1;
  logic req_valid = 1'b0;
  logic req_dac = 1'b0;
  logic req_long = 1'b0;
  logic [WORD_W-1:0] req_word = '0;
  logic req_ready, ser_clk, ser_dat, syn_en_n, dac_en_n, busy, done;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  serprog_top u0 (
    .clk(clk), .rst_n(rst_n), .radio_idle(radio_idle), .req_valid(req_valid),
    .req_ready(req_ready), .req_dac(req_dac), .req_long(req_long),
    .req_word(req_word), .ser_clk(ser_clk), .ser_dat(ser_dat),
    .syn_en_n(syn_en_n), .dac_en_n(dac_en_n), .busy(busy), .done(done)
  );

  always #(CLK_PERIOD/2) clk = !clk;

  // behavioural reference: k counts cycles since acceptance, -1 when idle
  int k = -1;
  int n = 0;
  logic m_tgt = 1'b0;
  bit q[$];

  always @(posedge clk) begin
    cycles = cycles + 1;
    if (!rst_n) k = -1;
    else if (k < 0) begin
      if (req_valid && (req_dac || radio_idle)) begin
        k = 0;
        m_tgt = req_dac;
        n = req_dac ? (req_long ? 12 : 10) : SYN_BITS;
        q.delete();
        for (int i = n - 1; i >= 0; i--) q.push_back(req_word[i]);
      end
    end else begin
      k = k + 1;
      if (k == 2*n + 2) k = -1;
    end
  end

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0b expected=%0b at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    logic e_act, e_clk, e_dat;
    e_act = (k >= 0) && (k <= 2*n);
    e_clk = (k >= 0) && (k < 2*n) && (k % 2 == 1);
    e_dat = ((k >= 0) && (k < 2*n)) ? q[k/2] : 1'b0;
    chk("R2 ser_clk", ser_clk, e_clk);
    chk("R3/R7 ser_dat", ser_dat, e_dat);
    chk("R4/R5 syn_en_n", syn_en_n, !(e_act && !m_tgt));
    chk("R4/R5 dac_en_n", dac_en_n, !(e_act && m_tgt));
    chk("R6 busy", busy, k >= 0);
    chk("R6 done", done, k == 2*n + 1);
    chk("R8/R9 req_ready", req_ready, (k < 0) && (req_dac || radio_idle));
  end

  always @(posedge clk) begin
    if (cycles > WDOG) begin
      errors++;
      $display("FAIL watchdog expired actual=hang expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic step(input int c);
    for (int i = 0; i < c; i++) @(negedge clk);
    #1;
  endtask

  task automatic offer(input logic dac, input logic lng, input logic [WORD_W-1:0] w, input int hold);
    req_dac = dac; req_long = lng; req_word = w; req_valid = 1'b1;
    step(hold);
    req_valid = 1'b0;
  endtask

  initial begin
    step(3);
    // R1 reset state
    chk("R1 reset syn_en_n", syn_en_n, 1'b1);
    chk("R1 reset dac_en_n", dac_en_n, 1'b1);
    chk("R1 reset ser_clk", ser_clk, 1'b0);
    chk("R1 reset busy", busy, 1'b0);
    rst_n = 1'b1;
    step(2);
    // R7 synthesizer word, radio idle
    offer(1'b0, 1'b0, 24'hA5C396, 1);
    step(60);
    // R7 R9 short DAC word with junk above bit 9, radio not idle, valid held
    radio_idle = 1'b0;
    offer(1'b1, 1'b0, 24'hFFF2B7, 40);
    step(40);
    // R7 long DAC word
    offer(1'b1, 1'b1, 24'h123C3A, 1);
    step(40);
    // R8 synthesizer offered while radio busy: must not start
    offer(1'b0, 1'b0, 24'h5A0F33, 12);
    chk("R8 synth held off syn_en_n", syn_en_n, 1'b1);
    chk("R8 synth held off busy", busy, 1'b0);
    // R8 offer again, idle goes high mid-offer
    req_valid = 1'b1; req_dac = 1'b0;
    step(3);
    radio_idle = 1'b1;
    step(1);
    req_valid = 1'b0;
    // idle drops mid transfer; transfer continues
    step(10);
    radio_idle = 1'b0;
    step(60);
    // R6 back to back DAC words with valid held
    offer(1'b1, 1'b1, 24'h000FFF, 70);
    step(40);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule